// File: doc/BRIEF.md
# Modem Control and Status Register Unit

This unit sits between a host register port and the four handshake lines a serial channel shares with its modem. A control register drives four active-low outputs (terminal ready, request to send and two general-purpose lines). A status register shows the asserted state of four active-low inputs (clear to send, set ready, ring and carrier), together with one sticky change flag for each input. Any set flag raises an interrupt request while the host has enabled that interrupt.

Each input pin passes through a synchronizer before its change is detected. A status read strobe clears the change flags. A loop mode lets the host test the channel without a modem. In loop mode the control bits feed the status inputs in place of the pins, and all four output pins are held inactive.

Top module: `modem_ctl_unit`

## Requirements
- R1: After reset, the control register reads 0, all four output pins are high, the whole status register reads 0 and the interrupt request is low.
- R2: With loop mode off, control bits 0, 1, 2 and 3 drive `dtr_n`, `rts_n`, `out1_n` and `out2_n` low when set and high when clear. Data bits 5 and above are ignored on a write, and those bits read as 0 on `ctl_q`.
- R3: Status bits 4, 5, 6 and 7 read 1 while `cts_n`, `dsr_n`, `ri_n` and `dcd_n` respectively are low. A pin change is visible after the third rising clock edge that follows it: two synchronizer stages plus the status register.
- R4: Status bits 0, 1 and 3 set when the status level of clear to send, set ready or carrier (bits 4, 5, 7) changes in either direction.
- R5: Status bit 2 sets only when `ri_n` goes from low to high (status bit 6 falls from 1 to 0). A high-to-low change of `ri_n` leaves bit 2 unchanged.
- R6: A set change flag stays set until a cycle in which `sts_rd` is high. On the next clock edge after that cycle, flags with no new change read 0.
- R7: A change detected on the same clock edge as a read leaves its flag set.
- R8: `irq` is high exactly when `irq_en` is high and at least one of status bits 0 to 3 is 1.
- R9: Control bit 4 selects loop mode. In loop mode all four output pins are high. Status bits 4, 5, 6 and 7 follow control bits 1, 0, 2 and 3, one clock after the control register, and the input pins are ignored. Changes produced this way set the change flags under the rules of R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| wr_data | input | DATA_W | Write data |
| sts_rd | input | 1 | Status read strobe, clears change flags |
| irq_en | input | 1 | Modem-status interrupt enable |
| ctl_q | output | DATA_W | Control register contents |
| sts_q | output | DATA_W | Status register contents |
| irq | output | 1 | Modem-status interrupt request |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | General-purpose output 1, active low |
| out2_n | output | 1 | General-purpose output 2, active low |

## Verification
The assertions check the following on every cycle:
- a change flag stays set without a read;
- a read clears a flag that has no new change;
- a change on the edge of a read is kept;
- every new flag matches the edge type its line allows;
- in loop mode the status levels mirror the earlier control bits;
- a control write lands.

Other behaviour shows up only in the bench's scenarios:
- the three-edge latency from pin to status;
- the inverted pin sense;
- a ring pin falling while its flag stays clear;
- the output pins being forced high in loop mode;
- upper data bits being dropped.

The bench also checks interrupt gating against random enable patterns.

// File: rtl/modem_pkg.sv
package modem_pkg;
   localparam int NLINES  = 4;
   localparam int LN_CTS  = 0;
   localparam int LN_DSR  = 1;
   localparam int LN_RI   = 2;
   localparam int LN_DCD  = 3;

   localparam int CTL_W   = 5;
   localparam int CB_DTR  = 0;
   localparam int CB_RTS  = 1;
   localparam int CB_OUT1 = 2;
   localparam int CB_OUT2 = 3;
   localparam int CB_LOOP = 4;

   localparam int STS_W   = 2 * NLINES;

   typedef logic [NLINES-1:0] line_vec_t;
   typedef logic [CTL_W-1:0]  ctl_vec_t;

   // Loop wiring: each status line takes the control bit paired with it.
   function automatic line_vec_t loop_map(input ctl_vec_t c);
      line_vec_t v;
      v[LN_CTS] = c[CB_RTS];
      v[LN_DSR] = c[CB_DTR];
      v[LN_RI]  = c[CB_OUT1];
      v[LN_DCD] = c[CB_OUT2];
      return v;
   endfunction
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
   parameter int STAGES  = 2,
   parameter int W       = 4,
   parameter logic RST_V = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("modem_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("modem_sync: W must be positive");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= {W{RST_V}};
            else        pipe[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= {W{RST_V}};
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q = pipe[LAST];
endmodule

// File: rtl/modem_ctl_reg.sv
module modem_ctl_reg
   import modem_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output ctl_vec_t          ctl,
   output logic              dtr_n,
   output logic              rts_n,
   output logic              out1_n,
   output logic              out2_n
);
   if (DATA_W < CTL_W) begin : g_bad_w
      $error("modem_ctl_reg: DATA_W narrower than control field");
   end

   ctl_vec_t ctl_r;
   logic     loop_on;
   logic     unused_hi;

   assign unused_hi = ^wdata[DATA_W-1:CTL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctl_r <= '0;
      else if (wr) ctl_r <= wdata[CTL_W-1:0];
   end

   assign loop_on = ctl_r[CB_LOOP];
   assign ctl     = ctl_r;

   // Pins are active low and forced inactive in loop mode.
   assign dtr_n  = ~(ctl_r[CB_DTR]  & ~loop_on);
   assign rts_n  = ~(ctl_r[CB_RTS]  & ~loop_on);
   assign out1_n = ~(ctl_r[CB_OUT1] & ~loop_on);
   assign out2_n = ~(ctl_r[CB_OUT2] & ~loop_on);

   AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> ctl == $past(wdata[CTL_W-1:0])); // R2
endmodule

// File: rtl/modem_delta.sv
module modem_delta #(
   parameter bit TRAIL_ONLY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   input  logic rd,
   output logic lvl,
   output logic flag
);
   logic lvl_q;
   logic flag_q;
   logic hit;

   if (TRAIL_ONLY) begin : g_trail
      assign hit = lvl_q & ~src;
   end else begin : g_any
      assign hit = lvl_q ^ src;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         lvl_q  <= src;
         flag_q <= (flag_q & ~rd) | hit;
      end
   end

   assign lvl  = lvl_q;
   assign flag = flag_q;

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !rd) |=> flag); // R6
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (lvl_q == src)) |=> !flag); // R6
   AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && hit) |=> flag); // R7

   if (TRAIL_ONLY) begin : g_chk_trail
      AST_TRAIL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag) |-> ($past(lvl) && !lvl)); // R5
   end else begin : g_chk_any
      AST_ANY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag) |-> (lvl != $past(lvl))); // R4
   end
endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
   import modem_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              sts_rd,
   input  logic              irq_en,
   output logic [DATA_W-1:0] ctl_q,
   output logic [DATA_W-1:0] sts_q,
   output logic              irq,
   input  logic              cts_n,
   input  logic              dsr_n,
   input  logic              ri_n,
   input  logic              dcd_n,
   output logic              dtr_n,
   output logic              rts_n,
   output logic              out1_n,
   output logic              out2_n
);
   if (DATA_W < STS_W) begin : g_bad_w
      $error("modem_ctl_unit: DATA_W narrower than status register");
   end

   ctl_vec_t  ctl;
   line_vec_t pins_n, sync_n, src, lvl, flag;

   assign pins_n[LN_CTS] = cts_n;
   assign pins_n[LN_DSR] = dsr_n;
   assign pins_n[LN_RI]  = ri_n;
   assign pins_n[LN_DCD] = dcd_n;

   modem_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(wr_data), .ctl(ctl),
      .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n)
   );

   modem_sync #(.STAGES(SYNC_STAGES), .W(NLINES), .RST_V(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pins_n), .q(sync_n)
   );

   assign src = ctl[CB_LOOP] ? loop_map(ctl) : ~sync_n;

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      modem_delta #(.TRAIL_ONLY(i == LN_RI)) u_delta (
         .clk(clk), .rst_n(rst_n), .src(src[i]), .rd(sts_rd),
         .lvl(lvl[i]), .flag(flag[i])
      );
   end

   assign sts_q = {{(DATA_W-STS_W){1'b0}}, lvl, flag};
   assign ctl_q = {{(DATA_W-CTL_W){1'b0}}, ctl};
   assign irq   = irq_en & (|flag);

   AST_LOOP_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[CB_LOOP] && $past(ctl[CB_LOOP])) |-> (lvl == loop_map($past(ctl)))); // R9
endmodule

// File: tb/sim_modem_ctl_unit.sv
`timescale 1ns/100ps
module sim_modem_ctl_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] wr_data = '0;
   logic       sts_rd = 1'b0;
   logic       irq_en = 1'b0;
   logic [7:0] ctl_q, sts_q;
   logic       irq;
   logic [3:0] pins = 4'hF;
   logic       dtr_n, rts_n, out1_n, out2_n;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // model state
   logic [3:0] m_s1 = 4'hF, m_s2 = 4'hF, m_lvl = 4'h0, m_flag = 4'h0;
   logic [4:0] m_ctl = 5'h0;

   always #2.5 clk = ~clk;

   modem_ctl_unit u0 (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wr_data(wr_data),
      .sts_rd(sts_rd), .irq_en(irq_en), .ctl_q(ctl_q), .sts_q(sts_q),
      .irq(irq), .cts_n(pins[0]), .dsr_n(pins[1]), .ri_n(pins[2]),
      .dcd_n(pins[3]), .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n),
      .out2_n(out2_n)
   );

   function automatic logic [3:0] f_loop(input logic [4:0] c);
      return {c[3], c[2], c[0], c[1]};
   endfunction

   function automatic logic [3:0] f_pins(input logic [4:0] c);
      return ~(c[3:0] & {4{~c[4]}});
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic [3:0] p, input logic wr, input logic [7:0] d,
                       input logic rd, input logic en, input string ftag);
      logic [3:0] src, setm;
      pins = p; ctl_wr = wr; wr_data = d; sts_rd = rd; irq_en = en;
      src  = m_ctl[4] ? f_loop(m_ctl) : ~m_s2;
      setm = ((src ^ m_lvl) & 4'b1011) | (m_lvl & ~src & 4'b0100);
      @(posedge clk);
      m_flag = (m_flag & (rd ? 4'h0 : 4'hF)) | setm;
      m_lvl  = src;
      m_s2   = m_s1;
      m_s1   = p;
      if (wr) m_ctl = d[4:0];
      @(negedge clk);
      chk(m_ctl[4] ? "R9" : "R2", {28'd0, out2_n, out1_n, rts_n, dtr_n}, {28'd0, f_pins(m_ctl)});
      chk(m_ctl[4] ? "R9" : "R3", {28'd0, sts_q[7:4]}, {28'd0, m_lvl});
      chk(ftag, {28'd0, sts_q[3:0]}, {28'd0, m_flag});
      chk("R8", {31'd0, irq}, {31'd0, en & (|m_flag)});
      chk("R2", {24'd0, ctl_q}, {27'd0, m_ctl});
   endtask

   task automatic idle(input int n, input string ftag);
      for (int i = 0; i < n; i++) step(pins, 1'b0, 8'h00, 1'b0, irq_en, ftag);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", {24'd0, sts_q}, 32'd0);
      chk("R1", {24'd0, ctl_q}, 32'd0);
      chk("R1", {28'd0, out2_n, out1_n, rts_n, dtr_n}, 32'hF);
      chk("R1", {31'd0, irq}, 32'd0);
      rst_n = 1'b1;
      idle(2, "R1");

      // R2: control bits drive pins low, upper bits dropped
      step(4'hF, 1'b1, 8'h0F, 1'b0, 1'b0, "R2");
      chk("R2", {28'd0, out2_n, out1_n, rts_n, dtr_n}, 32'h0);
      step(4'hF, 1'b1, 8'hE3, 1'b0, 1'b0, "R2");
      chk("R2", {24'd0, ctl_q}, 32'h03);
      chk("R2", {28'd0, out2_n, out1_n, rts_n, dtr_n}, 32'hC);

      // R3/R4: cts_n low, three edges to status
      step(4'hE, 1'b0, 8'h00, 1'b0, 1'b1, "R4");
      step(4'hE, 1'b0, 8'h00, 1'b0, 1'b1, "R4");
      chk("R3", {31'd0, sts_q[4]}, 32'd0);
      step(4'hE, 1'b0, 8'h00, 1'b0, 1'b1, "R4");
      chk("R3", {31'd0, sts_q[4]}, 32'd1);
      chk("R4", {31'd0, sts_q[0]}, 32'd1);
      chk("R8", {31'd0, irq}, 32'd1);
      idle(3, "R6");
      chk("R6", {31'd0, sts_q[0]}, 32'd1);
      step(4'hE, 1'b0, 8'h00, 1'b1, 1'b1, "R6");
      chk("R6", {28'd0, sts_q[3:0]}, 32'd0);
      chk("R8", {31'd0, irq}, 32'd0);

      // R5: ring falling pin sets nothing, rising pin sets bit 2
      step(4'hA, 1'b0, 8'h00, 1'b0, 1'b1, "R5");
      idle(3, "R5");
      chk("R5", {31'd0, sts_q[6]}, 32'd1);
      chk("R5", {31'd0, sts_q[2]}, 32'd0);
      step(4'hE, 1'b0, 8'h00, 1'b0, 1'b1, "R5");
      idle(3, "R5");
      chk("R5", {31'd0, sts_q[2]}, 32'd1);
      step(4'hE, 1'b0, 8'h00, 1'b1, 1'b0, "R6");
      chk("R8", {31'd0, irq}, 32'd0);

      // R7: dcd change lands on the read edge
      step(4'h6, 1'b0, 8'h00, 1'b0, 1'b0, "R7");
      step(4'h6, 1'b0, 8'h00, 1'b0, 1'b0, "R7");
      step(4'h6, 1'b0, 8'h00, 1'b1, 1'b0, "R7");
      chk("R7", {31'd0, sts_q[3]}, 32'd1);
      step(4'h6, 1'b0, 8'h00, 1'b1, 1'b0, "R6");

      // R9: loop mode
      step(4'h0, 1'b1, 8'h1F, 1'b0, 1'b1, "R9");
      chk("R9", {28'd0, out2_n, out1_n, rts_n, dtr_n}, 32'hF);
      step(4'h0, 1'b0, 8'h00, 1'b1, 1'b1, "R9");
      chk("R9", {28'd0, sts_q[7:4]}, 32'hF);
      step(4'hF, 1'b1, 8'h11, 1'b1, 1'b1, "R9");
      idle(4, "R9");
      chk("R9", {28'd0, sts_q[7:4]}, 32'h2);
      chk("R9", {31'd0, sts_q[2]}, 32'd1);
      step(4'hF, 1'b1, 8'h00, 1'b1, 1'b1, "R9");

      // random mix: R4 change flags under random stimulus
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] p;
         logic       w, r, e;
         logic [7:0] d;
         p = pins;
         for (int b = 0; b < 4; b++) if (($urandom % 4) == 0) p[b] = ~p[b];
         w = (($urandom % 10) == 0);
         d = 8'($urandom);
         r = (($urandom % 4) == 0);
         e = (($urandom % 2) == 0);
         step(p, w, d, r, e, "R4");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog act=running exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule